// File: doc/BRIEF.md
# Adaptive Vertical Chroma Averaging Filter

This block smooths demodulated U and V chroma in the vertical direction. Every output sample is a weighted mix of one sample and the samples at the same column on the line above it and the line below it. Two internal line buffers keep the two most recent lines. Output therefore runs one line behind input: while line k of a field is arriving, the filtered line k-1 is emitted, column by column, two clocks after the matching input pixel.

A two-bit mode input picks the behaviour. The block can average every sample, average only where the lines above and below agree to within a programmable threshold, or let the samples through unchanged. The correlation test runs separately for U and for V. The first line of a field has no line above it, so it always passes through unfiltered. A field-start strobe restarts the line count. If a field ends, the line still held in the buffer for that field is never emitted.

A line-start strobe resets the column position. The line buffers are as deep as `LINE_DEPTH`. Pixels beyond that depth on a line are neither stored nor emitted. A line longer than the line before it meets stale buffer contents in its extra columns.

Top module: `chroma_vfilt`

## Requirements
- R1: While reset is held and right after it, `outValid`, `uOut` and `vOut` are all zero.
- R2: No pixel of field line 0 produces an output. Each accepted pixel of field line k≥1 produces exactly one `outValid` pulse two clocks after it is sampled. That output belongs to line k-1 at the same column.
- R3: Output samples belonging to field line 0 equal the stored line-0 samples unchanged, in every mode.
- R4: With mode 2'b01, each component of a line k-1 output (k≥2) equals (above + 2·centre + below + 2) >> 2. Here "above" is line k-2, "centre" is line k-1 and "below" is line k, all at the same column. The result always fits 8 bits.
- R5: With mode 2'b10, a component is averaged as in R4 only when |above − below| is less than or equal to `thr`. Otherwise it equals the centre sample. U and V decide independently.
- R6: With mode 2'b00 or 2'b11, both components equal the centre sample.
- R7: `fieldStart` starts field line 0 and takes priority over `lineStart` in the same cycle. Lines of an earlier field are never used as the line above after a field start.
- R8: `lineStart` begins the next line at column 0. A pixel presented in the same cycle as `lineStart` or `fieldStart` is column 0, and each further pixel advances the column by one.
- R9: `mode` and `thr` are sampled together with each below-line pixel, so they may change from pixel to pixel.
- R10: The threshold comparison is inclusive: |above − below| equal to `thr` counts as correlated, and a threshold of 0 accepts only identical neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fieldStart | input | 1 | Marks the start of field line 0 |
| lineStart | input | 1 | Marks the start of the next line |
| pixValid | input | 1 | Input U/V sample valid |
| uIn | input | 8 | Demodulated U sample |
| vIn | input | 8 | Demodulated V sample |
| mode | input | 2 | 00 off, 01 always, 10 adaptive, 11 off |
| thr | input | 8 | Correlation threshold |
| outValid | output | 1 | Filtered sample valid |
| uOut | output | 8 | Filtered U |
| vOut | output | 8 | Filtered V |

## Verification
The embedded properties check four things on every cycle. Every output pulse must trace back to an input pixel two clocks earlier. First-line and off-mode samples must leave the lane untouched. Always-mode results must lie between the smallest and largest of their three taps. Adaptive mode must reject uncorrelated U neighbours. Only the bench scenarios can show the exact rounded averages and the inclusive threshold boundary. They also show column alignment when a start strobe coincides with a pixel, the absence of output during a field's first line, and that a field start hides the previous field's lines.

// File: rtl/chroma_vf_pkg.sv
package chroma_vf_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_ALWAYS  = 2'b01,
    MODE_ADAPT   = 2'b10,
    MODE_OFF_ALT = 2'b11
  } vfMode_e;

  // strobes from control to datapath, valid in the cycle a pixel is presented
  typedef struct packed {
    logic wr;        // store this pixel in the line buffers
    logic emit;      // produce an output for the line above it
    logic useAbove;  // a line two back exists in this field
    logic forceAvg;  // average with no correlation test
    logic adaptOn;   // average only where neighbours correlate
  } vfCtl_t;

endpackage

// File: rtl/chroma_vf_ctrl.sv
module chroma_vf_ctrl
  import chroma_vf_pkg::*;
#(
  parameter int LINE_DEPTH = 1024,
  localparam int ADDR_W = $clog2(LINE_DEPTH),
  localparam int COL_W  = $clog2(LINE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldStart,
  input  logic              lineStart,
  input  logic              pixValid,
  input  logic [1:0]        mode,
  output vfCtl_t            ctl,
  output logic [ADDR_W-1:0] addr
);

  logic [COL_W-1:0] colCnt, colNow;
  logic [1:0]       lineIdx, lineNow;
  logic             inRange;
  vfMode_e          modeSel;

  always_comb begin
    modeSel = vfMode_e'(mode);
    colNow  = (fieldStart || lineStart) ? '0 : colCnt;
    if (fieldStart)      lineNow = 2'd0;
    else if (lineStart)  lineNow = (lineIdx == 2'd2) ? 2'd2 : lineIdx + 2'd1;
    else                 lineNow = lineIdx;
    inRange      = colNow < COL_W'(LINE_DEPTH);
    ctl.wr       = pixValid && inRange;
    ctl.emit     = ctl.wr && (lineNow != 2'd0);
    ctl.useAbove = (lineNow == 2'd2);
    ctl.forceAvg = (modeSel == MODE_ALWAYS);
    ctl.adaptOn  = (modeSel == MODE_ADAPT);
    addr         = colNow[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt  <= '0;
      lineIdx <= 2'd0;
    end else begin
      colCnt  <= ctl.wr ? colNow + COL_W'(1) : colNow;
      lineIdx <= lineNow;
    end
  end

  // column position never runs past the buffer depth
  assert_col_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    colCnt <= COL_W'(LINE_DEPTH));

  // a field start always leaves the block on field line 0
  assert_field_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(fieldStart) |-> (lineIdx == 2'd0));

endmodule

// File: rtl/chroma_vf_lane.sv
module chroma_vf_lane #(
  parameter int SAMPLE_W = 8,
  localparam int SUM_W = SAMPLE_W + 2
) (
  input  logic [SAMPLE_W-1:0] above,
  input  logic [SAMPLE_W-1:0] centre,
  input  logic [SAMPLE_W-1:0] below,
  input  logic [SAMPLE_W-1:0] thr,
  input  logic                useAbove,
  input  logic                forceAvg,
  input  logic                adaptOn,
  output logic [SAMPLE_W-1:0] result
);

  logic [SUM_W-1:0]    sum;
  logic [SAMPLE_W-1:0] diff;
  logic                corr, take;

  always_comb begin
    sum  = {2'b00, above} + {1'b0, centre, 1'b0} + {2'b00, below} + SUM_W'(2);
    diff = (above > below) ? above - below : below - above;
    corr = (diff <= thr);
    take = useAbove && (forceAvg || (adaptOn && corr));
    result = take ? sum[SUM_W-1:2] : centre;
  end

endmodule

// File: rtl/chroma_vf_dpath.sv
module chroma_vf_dpath
  import chroma_vf_pkg::*;
#(
  parameter int LINE_DEPTH = 1024,
  parameter int SAMPLE_W   = 8,
  localparam int ADDR_W = $clog2(LINE_DEPTH),
  localparam int PAIR_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  vfCtl_t              ctl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SAMPLE_W-1:0] uIn,
  input  logic [SAMPLE_W-1:0] vIn,
  input  logic [SAMPLE_W-1:0] thr,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] uOut,
  output logic [SAMPLE_W-1:0] vOut
);

  // U sits in the upper half of each pair, V in the lower half
  logic [PAIR_W-1:0] memPrev [LINE_DEPTH];
  logic [PAIR_W-1:0] memOld  [LINE_DEPTH];

  logic [PAIR_W-1:0]   s1Above, s1Cur, s1Below, laneRes;
  logic [SAMPLE_W-1:0] s1Thr;
  logic                s1Emit, s1UseAbove, s1Force, s1Adapt;

  always_ff @(posedge clk) begin
    if (ctl.wr) begin
      memPrev[addr] <= {uIn, vIn};
      memOld[addr]  <= memPrev[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Emit     <= 1'b0;
      s1UseAbove <= 1'b0;
      s1Force    <= 1'b0;
      s1Adapt    <= 1'b0;
      s1Thr      <= '0;
      s1Above    <= '0;
      s1Cur      <= '0;
      s1Below    <= '0;
    end else begin
      s1Emit <= ctl.emit;
      if (ctl.wr) begin
        s1UseAbove <= ctl.useAbove;
        s1Force    <= ctl.forceAvg;
        s1Adapt    <= ctl.adaptOn;
        s1Thr      <= thr;
        s1Above    <= memOld[addr];
        s1Cur      <= memPrev[addr];
        s1Below    <= {uIn, vIn};
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : gLane
    chroma_vf_lane #(.SAMPLE_W(SAMPLE_W)) uLane (
      .above   (s1Above[i*SAMPLE_W +: SAMPLE_W]),
      .centre  (s1Cur[i*SAMPLE_W +: SAMPLE_W]),
      .below   (s1Below[i*SAMPLE_W +: SAMPLE_W]),
      .thr     (s1Thr),
      .useAbove(s1UseAbove),
      .forceAvg(s1Force),
      .adaptOn (s1Adapt),
      .result  (laneRes[i*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      uOut     <= '0;
      vOut     <= '0;
    end else begin
      outValid <= s1Emit;
      if (s1Emit) {uOut, vOut} <= laneRes;
    end
  end

  function automatic logic [SAMPLE_W-1:0] min3(input logic [SAMPLE_W-1:0] a, b, c);
    logic [SAMPLE_W-1:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic logic [SAMPLE_W-1:0] max3(input logic [SAMPLE_W-1:0] a, b, c);
    logic [SAMPLE_W-1:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [SAMPLE_W-1:0] absDiff(input logic [SAMPLE_W-1:0] a, b);
    return (a > b) ? a - b : b - a;
  endfunction

  assert_first_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    s1Emit && !s1UseAbove |=> ({uOut, vOut} == $past(s1Cur)));

  assert_pass_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    s1Emit && !s1Force && !s1Adapt |=> ({uOut, vOut} == $past(s1Cur)));

  assert_avg_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    s1Emit && s1UseAbove && s1Force |=>
      (uOut >= min3($past(s1Above[PAIR_W-1 -: SAMPLE_W]), $past(s1Cur[PAIR_W-1 -: SAMPLE_W]),
                    $past(s1Below[PAIR_W-1 -: SAMPLE_W]))) &&
      (uOut <= max3($past(s1Above[PAIR_W-1 -: SAMPLE_W]), $past(s1Cur[PAIR_W-1 -: SAMPLE_W]),
                    $past(s1Below[PAIR_W-1 -: SAMPLE_W]))));

  assert_adapt_reject_R5: assert property (@(posedge clk) disable iff (!rstN)
    s1Emit && s1UseAbove && s1Adapt &&
    (absDiff(s1Above[PAIR_W-1 -: SAMPLE_W], s1Below[PAIR_W-1 -: SAMPLE_W]) > s1Thr)
      |=> (uOut == $past(s1Cur[PAIR_W-1 -: SAMPLE_W])));

endmodule

// File: rtl/chroma_vfilt.sv
module chroma_vfilt
  import chroma_vf_pkg::*;
#(
  parameter int LINE_DEPTH = 1024,
  parameter int SAMPLE_W   = 8,
  localparam int ADDR_W = $clog2(LINE_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fieldStart,
  input  logic                lineStart,
  input  logic                pixValid,
  input  logic [SAMPLE_W-1:0] uIn,
  input  logic [SAMPLE_W-1:0] vIn,
  input  logic [1:0]          mode,
  input  logic [SAMPLE_W-1:0] thr,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] uOut,
  output logic [SAMPLE_W-1:0] vOut
);

  vfCtl_t            ctl;
  logic [ADDR_W-1:0] addr;

  chroma_vf_ctrl #(.LINE_DEPTH(LINE_DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .fieldStart(fieldStart),
    .lineStart (lineStart),
    .pixValid  (pixValid),
    .mode      (mode),
    .ctl       (ctl),
    .addr      (addr)
  );

  chroma_vf_dpath #(.LINE_DEPTH(LINE_DEPTH), .SAMPLE_W(SAMPLE_W)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addr    (addr),
    .uIn     (uIn),
    .vIn     (vIn),
    .thr     (thr),
    .outValid(outValid),
    .uOut    (uOut),
    .vOut    (vOut)
  );

  // every output pulse comes from a pixel two clocks earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pixValid, 2));

endmodule

// File: tb/chroma_vfilt_bench.sv
module chroma_vfilt_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fieldStart = 1'b0, lineStart = 1'b0, pixValid = 1'b0;
  logic [7:0] uIn = '0, vIn = '0, thr = '0;
  logic [1:0] mode = 2'b00;
  logic       outValid;
  logic [7:0] uOut, vOut;

  always #10 clk = ~clk;

  chroma_vfilt u_chroma_vfilt (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .lineStart(lineStart),
    .pixValid(pixValid), .uIn(uIn), .vIn(vIn), .mode(mode), .thr(thr),
    .outValid(outValid), .uOut(uOut), .vOut(vOut)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // capture
  logic [7:0] capU [64], capV [64];
  int         capCyc [64];
  int         capN = 0;
  always @(negedge clk) if (rstN && outValid && capN < 64) begin
    capU[capN] = uOut; capV[capN] = vOut; capCyc[capN] = cyc; capN++;
  end

  // line being driven
  logic [7:0] lnU [16], lnV [16], lnThr [16];
  logic [1:0] lnMode [16];
  int         inCyc [16];

  // stored lines for the expectation model
  logic [7:0] refAU [16], refAV [16], refCU [16], refCV [16];

  // table: above, centre, below, mode, thr, expected U
  localparam int NV = 13;
  localparam logic [47:0] VEC [NV] = '{
    {8'd10,  8'd50,  8'd30,  8'd1, 8'd0,   8'd35},
    {8'd255, 8'd255, 8'd255, 8'd1, 8'd0,   8'd255},
    {8'd0,   8'd0,   8'd0,   8'd1, 8'd0,   8'd0},
    {8'd0,   8'd1,   8'd2,   8'd1, 8'd0,   8'd1},
    {8'd100, 8'd40,  8'd110, 8'd2, 8'd10,  8'd73},
    {8'd100, 8'd40,  8'd111, 8'd2, 8'd10,  8'd40},
    {8'd200, 8'd0,   8'd0,   8'd2, 8'd255, 8'd50},
    {8'd0,   8'd255, 8'd255, 8'd2, 8'd0,   8'd255},
    {8'd5,   8'd77,  8'd5,   8'd2, 8'd0,   8'd41},
    {8'd10,  8'd50,  8'd30,  8'd0, 8'd0,   8'd50},
    {8'd10,  8'd50,  8'd30,  8'd3, 8'd0,   8'd50},
    {8'd1,   8'd2,   8'd4,   8'd1, 8'd0,   8'd2},
    {8'd3,   8'd3,   8'd4,   8'd1, 8'd0,   8'd3}
  };

  function automatic logic [7:0] vOf(input logic [7:0] u);
    return u ^ 8'h3C;
  endfunction

  // model from the requirements: R4, R5, R6
  function automatic int model(input int a, input int c, input int b, input logic [1:0] md, input int th);
    int d;
    d = (a > b) ? a - b : b - a;
    if (md == 2'b01 || (md == 2'b10 && d <= th)) return (a + 2 * c + b + 2) / 4;
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fieldStart = 0; lineStart = 0; pixValid = 0;
    end
  endtask

  task automatic sendLine(input bit isField, input bit merged, input int n);
    if (!merged) begin
      @(negedge clk);
      fieldStart = isField; lineStart = !isField; pixValid = 0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fieldStart = merged && i == 0 && isField;
      lineStart  = merged && i == 0 && !isField;
      pixValid = 1; uIn = lnU[i]; vIn = lnV[i]; mode = lnMode[i]; thr = lnThr[i];
      inCyc[i] = cyc;
    end
    idle(4);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 valid in reset", outValid, 0);
    chk("R1 u in reset", uOut, 0);
    chk("R1 v in reset", vOut, 0);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    chk("R1 valid after reset", outValid, 0);
    chk("R1 u after reset", uOut, 0);

    // ---- table walk: column i carries vector i ----
    for (int i = 0; i < NV; i++) begin
      lnU[i] = VEC[i][47:40]; lnV[i] = vOf(VEC[i][47:40]);
      lnMode[i] = 2'b01; lnThr[i] = 8'd0;
    end
    capN = 0;
    sendLine(1'b1, 1'b0, NV);
    chk("R2 no output on field line 0", capN, 0);
    for (int i = 0; i < NV; i++) begin
      lnU[i] = VEC[i][39:32]; lnV[i] = vOf(VEC[i][39:32]);
    end
    capN = 0;
    sendLine(1'b0, 1'b0, NV);
    chk("R2 output count line 1", capN, NV);
    for (int i = 0; i < NV; i++) begin
      chk("R3 first line U passes", capU[i], VEC[i][47:40]);
      chk("R3 first line V passes", capV[i], vOf(VEC[i][47:40]));
      chk("R2 latency", capCyc[i] - inCyc[i], 2);
    end
    for (int i = 0; i < NV; i++) begin
      lnU[i] = VEC[i][31:24]; lnV[i] = vOf(VEC[i][31:24]);
      lnMode[i] = VEC[i][17:16]; lnThr[i] = VEC[i][15:8];
    end
    capN = 0;
    sendLine(1'b0, 1'b0, NV);
    chk("R2 output count line 2", capN, NV);
    for (int i = 0; i < NV; i++) begin
      // R4 R5 R6 R9 R10: per-column mode and threshold
      chk("R4/R5/R6/R9/R10 U vs table", capU[i], VEC[i][7:0]);
      chk("R5 V independent model", capV[i],
          model(vOf(VEC[i][47:40]), vOf(VEC[i][39:32]), vOf(VEC[i][31:24]),
                VEC[i][17:16], VEC[i][15:8]));
    end

    // ---- R7: new field mid-stream; old lines must not act as above ----
    for (int i = 0; i < 6; i++) begin
      lnU[i] = 8'd7; lnV[i] = 8'd9; lnMode[i] = 2'b01; lnThr[i] = 8'd0;
    end
    capN = 0;
    sendLine(1'b1, 1'b0, 6);
    chk("R7 no output on new field line 0", capN, 0);
    for (int i = 0; i < 6; i++) begin
      lnU[i] = 8'd200; lnV[i] = 8'd100; refAU[i] = 8'd7; refAV[i] = 8'd9;
    end
    capN = 0;
    sendLine(1'b0, 1'b0, 6);
    chk("R7 output count", capN, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R7 U unfiltered after field start", capU[i], 7);
      chk("R7 V unfiltered after field start", capV[i], 9);
      refCU[i] = 8'd200; refCV[i] = 8'd100;
    end

    // ---- R8: lineStart merged with first pixel keeps column alignment ----
    for (int i = 0; i < 6; i++) begin
      lnU[i] = 8'(i * 10); lnV[i] = 8'(250 - i * 7); lnMode[i] = 2'b01;
    end
    capN = 0;
    sendLine(1'b0, 1'b1, 6);
    chk("R8 output count merged start", capN, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R8 U column aligned", capU[i], model(refAU[i], refCU[i], i * 10, 2'b01, 0));
      chk("R8 V column aligned", capV[i], model(refAV[i], refCV[i], 250 - i * 7, 2'b01, 0));
    end

    // ---- R7: fieldStart and lineStart together counts as field start ----
    @(negedge clk); fieldStart = 1; lineStart = 1; pixValid = 0;
    for (int i = 0; i < 4; i++) begin lnU[i] = 8'd60; lnV[i] = 8'd61; end
    capN = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      fieldStart = 0; lineStart = 0; pixValid = 1; uIn = lnU[i]; vIn = lnV[i]; mode = 2'b01;
    end
    idle(4);
    chk("R7 both strobes: no output", capN, 0);

    // ---- R6: mode off across a whole line ----
    for (int i = 0; i < 4; i++) begin
      lnU[i] = 8'd0; lnV[i] = 8'd255; lnMode[i] = 2'b00;
    end
    sendLine(1'b0, 1'b0, 4);
    for (int i = 0; i < 4; i++) lnU[i] = 8'd250;
    capN = 0;
    sendLine(1'b0, 1'b0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 off mode U", capU[i], 0);
      chk("R6 off mode V", capV[i], 255);
    end

    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

endmodule